// File: doc/BRIEF.md
# Registered Opcode ALU

This block is a 16-bit arithmetic and logic unit placed between two register stages. On each rising clock edge it captures two operands, a 4-bit operation code and a carry-in into an input stage. A combinational core then evaluates the selected operation. The result word and three flags are captured into an output stage on the following edge.

A new operation can be presented on every cycle, and each result appears two edges after its operands were presented. The core covers addition with carry and subtraction with a carry flag. It also covers equality and inequality tests, five bitwise functions and two operand pass-throughs. Any code outside the defined set gives an all-zero output.

Parameters set the data width and choose between a bit-level ripple adder and a behavioural adder. Both adders give the same results.

Top module: `regalu_top`

## Requirements
- R1: Inputs presented before rising edge k are captured on edge k, and their result appears on the outputs after edge k+1. Between those two edges the outputs still show the previous operation, and a new operation is accepted every cycle.
- R2: When `rst` is high at a rising edge, both register stages clear, so all outputs read zero after that edge.
- R3: Code 4'b0000 produces `{cy_out,res_out} = a + b + cin` as a 17-bit sum. For example, 0xFFFF + 0x0001 with carry-in 0 gives result 0x0000 with `cy_out` = 1.
- R4: Code 4'b0001 produces `res_out = a - b`. `cy_out` is the carry out of a + ~b + 1, which is 1 exactly when a >= b unsigned. `cin_in` has no effect under this code.
- R5: Code 4'b0010 sets `cmp_out` when a == b, and code 4'b0011 sets it when a != b. Under both codes `res_out` is zero and `cy_out` is 0.
- R6: The bitwise functions are XOR for code 4'b0100, NOR for 4'b0101, OR for 4'b0110, AND for 4'b0111 and NAND for 4'b1010.
- R7: Code 4'b1000 copies `a` to `res_out`, and code 4'b1001 copies `b` to `res_out`.
- R8: Codes 4'b1011 through 4'b1111 drive `res_out`, `cy_out`, `zf_out` and `cmp_out` all to zero.
- R9: For every defined code, `zf_out` is 1 exactly when `res_out` is zero. `cmp_out` is 0 for every code other than the two compares, and `cy_out` is 0 for every code other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset for both stages |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| opc_in | input | 4 | Operation code |
| cin_in | input | 1 | Carry-in, used only by the add code |
| res_out | output | 16 | Registered result word |
| cy_out | output | 1 | Registered carry flag |
| zf_out | output | 1 | Registered zero flag |
| cmp_out | output | 1 | Registered compare flag |

## Verification
On every cycle, the bound checker compares the outputs with the port inputs from two edges earlier. It checks the add sum, the pass-through of A and the all-zero output for undefined codes. It also checks that the carry flag appears only after arithmetic codes, that a set compare flag comes with a zero result, and that the zero flag matches the result. Subtraction wraparound, the bitwise functions, cycle-accurate latency under back-to-back operations and the clearing effect of a mid-stream reset are shown only by the bench's vector table and directed scenarios.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD   = 4'b0000,
      OPC_SUB   = 4'b0001,
      OPC_EQ    = 4'b0010,
      OPC_NE    = 4'b0011,
      OPC_XOR   = 4'b0100,
      OPC_NOR   = 4'b0101,
      OPC_OR    = 4'b0110,
      OPC_AND   = 4'b0111,
      OPC_PASSA = 4'b1000,
      OPC_PASSB = 4'b1001,
      OPC_NAND  = 4'b1010
   } opc_e;

   localparam logic [OPC_W-1:0] OPC_LAST_DEFINED = 4'b1010;

   function automatic logic opc_defined(input logic [OPC_W-1:0] code);
      return code <= OPC_LAST_DEFINED;
   endfunction

endpackage

// File: rtl/regalu_pipe_reg.sv
module regalu_pipe_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("regalu_pipe_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/regalu_adder.sv
module regalu_adder #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);

   if (RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = ci;
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic p;
         assign p      = x[i] ^ y[i];
         assign s[i]   = p ^ c[i];
         assign c[i+1] = (x[i] & y[i]) | (p & c[i]);
      end
      assign co = c[W];
   end else begin : g_flat
      logic [W:0] sum;
      assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      assign s   = sum[W-1:0];
      assign co  = sum[W];
   end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
   import regalu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [OPC_W-1:0]  opc,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cy,
   output logic              zf,
   output logic              cmp
);

   logic              is_sub;
   logic [DATA_W-1:0] add_y;
   logic              add_ci;
   logic [DATA_W-1:0] add_s;
   logic              add_co;

   assign is_sub = (opc == OPC_SUB);
   assign add_y  = is_sub ? ~b : b;
   assign add_ci = is_sub ? 1'b1 : cin;

   regalu_adder #(.W(DATA_W), .RIPPLE(RIPPLE_ADD)) u_add (
      .x (a),
      .y (add_y),
      .ci(add_ci),
      .s (add_s),
      .co(add_co)
   );

   always_comb begin
      res = '0;
      cy  = 1'b0;
      cmp = 1'b0;
      case (opc)
         OPC_ADD, OPC_SUB: begin
            res = add_s;
            cy  = add_co;
         end
         OPC_EQ:    cmp = (a == b);
         OPC_NE:    cmp = (a != b);
         OPC_XOR:   res = a ^ b;
         OPC_NOR:   res = ~(a | b);
         OPC_OR:    res = a | b;
         OPC_AND:   res = a & b;
         OPC_NAND:  res = ~(a & b);
         OPC_PASSA: res = a;
         OPC_PASSB: res = b;
         default: begin
            res = '0;
            cy  = 1'b0;
            cmp = 1'b0;
         end
      endcase
      zf = opc_defined(opc) && (res == '0);
   end

endmodule

// File: rtl/regalu_top.sv
module regalu_top
   import regalu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [OPC_W-1:0]  opc_in,
   input  logic              cin_in,
   output logic [DATA_W-1:0] res_out,
   output logic              cy_out,
   output logic              zf_out,
   output logic              cmp_out
);

   localparam int IN_W  = 2*DATA_W + OPC_W + 1;
   localparam int OUT_W = DATA_W + 3;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("regalu_top: DATA_W must be at least 2");
   end

   logic [IN_W-1:0]   in_d, in_q;
   logic [OUT_W-1:0]  out_d, out_q;
   logic [DATA_W-1:0] a_r, b_r, c_res;
   logic [OPC_W-1:0]  opc_r;
   logic              cin_r, c_cy, c_zf, c_cmp;

   assign in_d = {a_in, b_in, opc_in, cin_in};

   regalu_pipe_reg #(.WIDTH(IN_W)) u_in_stage (
      .clk(clk), .rst(rst), .d(in_d), .q(in_q)
   );

   assign {a_r, b_r, opc_r, cin_r} = in_q;

   regalu_core #(.DATA_W(DATA_W), .RIPPLE_ADD(RIPPLE_ADD)) u_core (
      .a  (a_r),
      .b  (b_r),
      .opc(opc_r),
      .cin(cin_r),
      .res(c_res),
      .cy (c_cy),
      .zf (c_zf),
      .cmp(c_cmp)
   );

   assign out_d = {c_res, c_cy, c_zf, c_cmp};

   regalu_pipe_reg #(.WIDTH(OUT_W)) u_out_stage (
      .clk(clk), .rst(rst), .d(out_d), .q(out_q)
   );

   assign {res_out, cy_out, zf_out, cmp_out} = out_q;

endmodule

// File: rtl/regalu_chk.sv
module regalu_chk
   import regalu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] b_in,
   input logic [OPC_W-1:0]  opc_in,
   input logic              cin_in,
   input logic [DATA_W-1:0] res_out,
   input logic              cy_out,
   input logic              zf_out,
   input logic              cmp_out
);

   // Counts clean edges since reset; two are needed before $past(x,2) is meaningful.
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)              warm <= 2'd0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   logic ready;
   assign ready = (warm == 2'd2);

   // R3
   p_add_sum_r3: assert property (@(posedge clk) disable iff (rst || !ready)
      ($past(opc_in, 2) == 4'b0000) |->
      ({cy_out, res_out} == ({1'b0, $past(a_in, 2)} + {1'b0, $past(b_in, 2)}
                             + {{DATA_W{1'b0}}, $past(cin_in, 2)})));

   // R7
   p_pass_a_r7: assert property (@(posedge clk) disable iff (rst || !ready)
      ($past(opc_in, 2) == 4'b1000) |-> (res_out == $past(a_in, 2)));

   // R8
   p_undef_quiet_r8: assert property (@(posedge clk) disable iff (rst || !ready)
      ($past(opc_in, 2) > 4'b1010) |->
      (res_out == '0 && !cy_out && !zf_out && !cmp_out));

   // R9
   p_cy_arith_r9: assert property (@(posedge clk) disable iff (rst || !ready)
      cy_out |-> ($past(opc_in, 2) <= 4'b0001));

   // R5 and R9
   p_cmp_excl_r5: assert property (@(posedge clk) disable iff (rst || !ready)
      cmp_out |-> (res_out == '0 && !cy_out &&
                   ($past(opc_in, 2) == 4'b0010 || $past(opc_in, 2) == 4'b0011)));

   // R9
   p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst || !ready)
      ($past(opc_in, 2) <= 4'b1010) |-> (zf_out == (res_out == '0)));

endmodule

bind regalu_top regalu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .opc_in(opc_in),
   .cin_in(cin_in), .res_out(res_out), .cy_out(cy_out), .zf_out(zf_out),
   .cmp_out(cmp_out)
);

// File: tb/regalu_top_tb_top.sv
module regalu_top_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] a_in, b_in, res_out;
   logic [3:0]  opc_in;
   logic        cin_in, cy_out, zf_out, cmp_out;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   regalu_top dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .opc_in(opc_in),
      .cin_in(cin_in), .res_out(res_out), .cy_out(cy_out), .zf_out(zf_out),
      .cmp_out(cmp_out)
   );

   // Vector fields: a, b, opc, cin | expected res, cy, zf, cmp
   localparam int NV = 19;
   localparam logic [55:0] VEC [NV] = '{
      {16'hFFFF, 16'h0001, 4'h0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
      {16'h1234, 16'h1111, 4'h0, 1'b1, 16'h2346, 1'b0, 1'b0, 1'b0},
      {16'hFFFF, 16'hFFFF, 4'h0, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0},
      {16'hAAAA, 16'h1555, 4'h1, 1'b0, 16'h9555, 1'b1, 1'b0, 1'b0},
      {16'h0001, 16'h0002, 4'h1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0},
      {16'h7777, 16'h7777, 4'h1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
      {16'h5555, 16'h5555, 4'h2, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1},
      {16'h5555, 16'hAAAA, 4'h2, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
      {16'h5555, 16'hAAAA, 4'h3, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1},
      {16'h5555, 16'hAAAA, 4'h4, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},
      {16'h5555, 16'hAAAA, 4'h5, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
      {16'h0F00, 16'h00F0, 4'h6, 1'b0, 16'h0FF0, 1'b0, 1'b0, 1'b0},
      {16'hF0F0, 16'hFF00, 4'h7, 1'b1, 16'hF000, 1'b0, 1'b0, 1'b0},
      {16'h6666, 16'h0000, 4'hA, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0},
      {16'h1357, 16'h2468, 4'h8, 1'b0, 16'h1357, 1'b0, 1'b0, 1'b0},
      {16'h1357, 16'h2468, 4'h9, 1'b0, 16'h2468, 1'b0, 1'b0, 1'b0},
      {16'h0000, 16'hFFFF, 4'h8, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0},
      {16'hFFFF, 16'hFFFF, 4'hB, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0},
      {16'h0000, 16'h0000, 4'hF, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0}
   };

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'h0:             return "R3";
         4'h1:             return "R4";
         4'h2, 4'h3:       return "R5";
         4'h8, 4'h9:       return "R7";
         4'h4, 4'h5, 4'h6,
         4'h7, 4'hA:       return "R6";
         default:          return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [18:0] exp);
      logic [18:0] got;
      got = {res_out, cy_out, zf_out, cmp_out};
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got res=%h cy=%b zf=%b cmp=%b, expected res=%h cy=%b zf=%b cmp=%b",
                  tag, got[18:3], got[2], got[1], got[0],
                  exp[18:3], exp[2], exp[1], exp[0]);
      end
   endtask

   task automatic drive(input logic [36:0] v);
      {a_in, b_in, opc_in, cin_in} = v;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      rst = 1'b1;
      drive({16'hABCD, 16'h1234, 4'h0, 1'b1});
      repeat (3) @(posedge clk);
      #1;
      check("R2 reset state", 19'h0);

      // R1: latency - release reset and present a pass-A at the same time
      @(negedge clk);
      rst = 1'b0;
      drive({16'h1111, 16'h2222, 4'h8, 1'b0});
      @(posedge clk); #1;
      // in stage held zeros (add 0+0) -> zero result, zero flag set
      check("R1 not yet visible", {16'h0000, 1'b0, 1'b1, 1'b0});
      @(negedge clk);
      drive({16'h1111, 16'h2222, 4'h9, 1'b0});
      @(posedge clk); #1;
      check("R1 first result", {16'h1111, 1'b0, 1'b0, 1'b0});
      @(negedge clk);
      drive({16'h0000, 16'h0000, 4'hC, 1'b0});
      @(posedge clk); #1;
      check("R1 back-to-back", {16'h2222, 1'b0, 1'b0, 1'b0});

      // Vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][55:19]);
         @(posedge clk);
         @(posedge clk); #1;
         check(tag_of(VEC[i][22:19]), VEC[i][18:0]);
      end

      // R4: carry-in has no effect on subtract
      @(negedge clk);
      drive({16'h0010, 16'h0001, 4'h1, 1'b1});
      @(posedge clk); @(posedge clk); #1;
      check("R4 cin ignored", {16'h000F, 1'b1, 1'b0, 1'b0});

      // R9: NE on equal operands leaves compare low and zero flag high
      @(negedge clk);
      drive({16'hBEEF, 16'hBEEF, 4'h3, 1'b0});
      @(posedge clk); @(posedge clk); #1;
      check("R9 compare false", {16'h0000, 1'b0, 1'b1, 1'b0});

      // R2: mid-stream reset clears both stages
      @(negedge clk);
      drive({16'hFFFF, 16'h0001, 4'h0, 1'b1});
      @(posedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1;
      check("R2 mid-run reset", 19'h0);
      @(negedge clk);
      rst = 1'b0;
      drive({16'h0000, 16'h0000, 4'hD, 1'b0});
      @(posedge clk); #1;
      // in stage was cleared to add 0+0, so the prior add is lost
      check("R2 cleared input stage", {16'h0000, 1'b0, 1'b1, 1'b0});

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         finish_run();
      end
   end

endmodule